// File: doc/BRIEF.md
# Configurable-aspect single-port SRAM

This block is a single-port synchronous memory that always holds 16,384 bits. The word width is fixed at build time to 1, 2, 4, 8, 16 or 32 bits. The number of words, and so the address width, follows from that choice: 14 address bits at width 1, down to 9 bits at width 32. All access inputs are registered on one clock before they reach the array. The address, write data, read/write strobe and the two chip-select inputs are all sampled that way, and the clock enable gates every register.

The read port is built one of two ways. In the registered form, a read issued before one active edge appears after the next one, and the output stays put on write or deselected cycles. In the combinational form, the output always shows the array word at the captured address.

An asynchronous reset clears the input registers and the output register, but it does not clear the array. The reset is active when a global reset or a local reset is active. The local reset, the clock and the clock enable each have a build-time polarity inversion.

Top module: `cfg_spram`

## Requirements
- R1: Each of the 16384/DATA_W addresses (ADDR_W = log2 of that count) holds its own DATA_W-bit word, independent of every other address, at every legal DATA_W.
- R2: Access inputs act only through the values captured at an active clock edge. A change made after that edge does not alter the access that edge started.
- R3: When cs_a, cs_b and wr are all 1 at a capturing edge, wdata is stored at addr on the following active edge.
- R4: If cs_a or cs_b is 0 at the capturing edge, nothing is written, and in registered mode rdata keeps its value.
- R5: In registered mode (OUT_REG=1), the word at addr appears on rdata after the second active edge following a read presented with wr=0 and both selects 1. rdata is unchanged after a write cycle.
- R6: In combinational mode (OUT_REG=0), rdata equals the word at the most recently captured address. After a write to that address, it shows the new word once the writing edge has passed.
- R7: While the clock enable is inactive (clk_en=0, or clk_en=1 when INV_CEN=1), no input is captured, the array is not written and rdata does not change.
- R8: Reset acts without a clock. It clears rdata to 0 in registered mode and drops any captured access, so an access pending during reset never writes. Array contents survive reset.
- R9: Reset is active when glb_rst=1 or the local reset is active: loc_rst=1 if INV_LRST=0, or loc_rst=0 if INV_LRST=1. Either source alone resets the block.
- R10: With INV_CLK=0 the active edge is the rising edge of clk. With INV_CLK=1 it is the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; active edge chosen by INV_CLK |
| glb_rst | input | 1 | Global asynchronous reset, active high |
| loc_rst | input | 1 | Local asynchronous reset, polarity set by INV_LRST |
| clk_en | input | 1 | Clock enable for all registers, polarity set by INV_CEN |
| cs_a | input | 1 | Chip select A, active high |
| cs_b | input | 1 | Chip select B, active high |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, registered or combinational |

## Verification
The hardest case to reach is a reset that arrives while a write has been presented but not yet captured. It must leave the array untouched while still clearing the output. The bench presents a write and raises one reset source a fraction of a period before the active edge. It releases the reset after that edge and then reads the location back. It does this once for each reset source. The second hard case is telling the active edge apart from the inactive one. The bench changes the inputs just after the active edge, which only a design that samples the wrong edge would notice. Every legal width is swept over its full address range against an arithmetic pattern.

// File: rtl/spram_pkg.sv
package spram_pkg;

  // Storage geometry shared by every aspect ratio
  localparam int unsigned ARRAY_BITS = 16384;
  localparam int unsigned PHYS_W     = 32;
  localparam int unsigned PHYS_ROWS  = ARRAY_BITS / PHYS_W;
  localparam int unsigned ROW_AW     = $clog2(PHYS_ROWS);

  function automatic int unsigned addr_bits(input int unsigned dw);
    return $clog2(ARRAY_BITS / dw);
  endfunction

  function automatic bit width_ok(input int unsigned dw);
    return (dw == 1) || (dw == 2) || (dw == 4) || (dw == 8) || (dw == 16) || (dw == 32);
  endfunction

endpackage

// File: rtl/spram_ctrl.sv
module spram_ctrl #(
  parameter bit INV_CLK  = 1'b0,
  parameter bit INV_CEN  = 1'b0,
  parameter bit INV_LRST = 1'b0
) (
  input  logic clk,
  input  logic glb_rst,
  input  logic loc_rst,
  input  logic clk_en,
  output logic clk_act,
  output logic rst_act,
  output logic en_act
);

  // Polarity conditioning of the shared clock, enable and reset
  assign clk_act = INV_CLK  ? ~clk     : clk;
  assign en_act  = INV_CEN  ? ~clk_en  : clk_en;
  assign rst_act = glb_rst | (INV_LRST ? ~loc_rst : loc_rst);

endmodule

// File: rtl/spram_inreg.sv
module spram_inreg #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cs_a,
  input  logic              cs_b,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              sel_q,
  output logic              wr_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sel_q   <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (en) begin
      sel_q   <= cs_a & cs_b;
      wr_q    <= wr;
      addr_q  <= addr;
      wdata_q <= wdata;
    end
  end

endmodule

// File: rtl/spram_array.sv
module spram_array
  import spram_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rword
);

  localparam int unsigned LANES   = PHYS_W / DATA_W;
  localparam int unsigned LANE_W  = $clog2(LANES);
  localparam int unsigned LANE_SW = (LANE_W == 0) ? 1 : LANE_W;

  logic [PHYS_W-1:0]  mem [PHYS_ROWS];
  logic [ROW_AW-1:0]  row;
  logic [LANE_SW-1:0] lane;
  logic [5:0]         shamt;
  logic [PHYS_W-1:0]  wmask;
  logic [PHYS_W-1:0]  wrep;
  logic [PHYS_W-1:0]  row_word;

  // Upper address bits pick the physical row, lower bits the lane within it
  assign row = addr[ADDR_W-1 -: ROW_AW];

  generate
    if (LANE_W == 0) begin : g_full_row
      assign lane = '0;
    end else begin : g_lanes
      assign lane = addr[LANE_W-1:0];
    end
  endgenerate

  assign shamt    = 6'(lane) * 6'(DATA_W);
  assign wmask    = PHYS_W'({DATA_W{1'b1}}) << shamt;
  assign wrep     = {LANES{wdata}};
  assign row_word = mem[row];
  assign rword    = DATA_W'(row_word >> shamt);

  always_ff @(posedge clk) begin
    if (we) begin
      mem[row] <= (row_word & ~wmask) | (wrep & wmask);
    end
  end

endmodule

// File: rtl/spram_rdpath.sv
module spram_rdpath #(
  parameter int unsigned DATA_W  = 8,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              rd_ok,
  input  logic [DATA_W-1:0] aword,
  output logic [DATA_W-1:0] rdata
);

  generate
    if (OUT_REG) begin : g_registered
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
          rdata_q <= '0;
        end else if (en && rd_ok) begin
          rdata_q <= aword;
        end
      end
      assign rdata = rdata_q;
    end else begin : g_flow
      logic unused_ctl;
      assign unused_ctl = ^{clk, rst, en, rd_ok};
      assign rdata      = aword;
    end
  endgenerate

endmodule

// File: rtl/cfg_spram.sv
module cfg_spram
  import spram_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter bit          OUT_REG  = 1'b1,
  parameter bit          INV_CLK  = 1'b0,
  parameter bit          INV_CEN  = 1'b0,
  parameter bit          INV_LRST = 1'b0,
  localparam int unsigned ADDR_W  = addr_bits(DATA_W)
) (
  input  logic              clk,
  input  logic              glb_rst,
  input  logic              loc_rst,
  input  logic              clk_en,
  input  logic              cs_a,
  input  logic              cs_b,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  generate
    if (!width_ok(DATA_W)) begin : g_bad_width
      $error("cfg_spram: DATA_W must be 1, 2, 4, 8, 16 or 32");
    end
  endgenerate

  logic              clk_act;
  logic              rst_act;
  logic              en_act;
  logic              sel_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] aword;
  logic              we;
  logic              rd_ok;

  spram_ctrl #(
    .INV_CLK (INV_CLK),
    .INV_CEN (INV_CEN),
    .INV_LRST(INV_LRST)
  ) u_ctrl (
    .clk    (clk),
    .glb_rst(glb_rst),
    .loc_rst(loc_rst),
    .clk_en (clk_en),
    .clk_act(clk_act),
    .rst_act(rst_act),
    .en_act (en_act)
  );

  spram_inreg #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_inreg (
    .clk    (clk_act),
    .rst    (rst_act),
    .en     (en_act),
    .cs_a   (cs_a),
    .cs_b   (cs_b),
    .wr     (wr),
    .addr   (addr),
    .wdata  (wdata),
    .sel_q  (sel_q),
    .wr_q   (wr_q),
    .addr_q (addr_q),
    .wdata_q(wdata_q)
  );

  assign we    = en_act & sel_q & wr_q;
  assign rd_ok = sel_q & ~wr_q;

  spram_array #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_array (
    .clk  (clk_act),
    .we   (we),
    .addr (addr_q),
    .wdata(wdata_q),
    .rword(aword)
  );

  spram_rdpath #(
    .DATA_W (DATA_W),
    .OUT_REG(OUT_REG)
  ) u_rdpath (
    .clk  (clk_act),
    .rst  (rst_act),
    .en   (en_act),
    .rd_ok(rd_ok),
    .aword(aword),
    .rdata(rdata)
  );

endmodule

// File: rtl/spram_chk.sv
module spram_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter bit          OUT_REG  = 1'b1,
  parameter bit          INV_CLK  = 1'b0,
  parameter bit          INV_CEN  = 1'b0,
  parameter bit          INV_LRST = 1'b0
) (
  input logic              clk,
  input logic              glb_rst,
  input logic              loc_rst,
  input logic              clk_en,
  input logic              cs_a,
  input logic              cs_b,
  input logic              wr,
  input logic [DATA_W-1:0] rdata
);

  logic clk_c;
  logic rst_c;
  logic en_c;
  logic sel_p;
  logic wr_p;

  assign clk_c = clk ^ INV_CLK;
  assign rst_c = glb_rst | (loc_rst ^ INV_LRST);
  assign en_c  = clk_en ^ INV_CEN;

  // Shadow of the access captured at the previous active edge
  always_ff @(posedge clk_c or posedge rst_c) begin
    if (rst_c) begin
      sel_p <= 1'b0;
      wr_p  <= 1'b0;
    end else if (en_c) begin
      sel_p <= cs_a & cs_b;
      wr_p  <= wr;
    end
  end

  generate
    if (OUT_REG) begin : g_reg_checks
      // R8
      a_r8_reset_clears: assert property (@(posedge clk_c)
        rst_c |-> (rdata == '0));
      // R7
      a_r7_enable_hold: assert property (@(posedge clk_c) disable iff (rst_c)
        !en_c |=> $stable(rdata));
      // R5
      a_r5_write_hold: assert property (@(posedge clk_c) disable iff (rst_c)
        (en_c && sel_p && wr_p) |=> $stable(rdata));
      // R4
      a_r4_deselect_hold: assert property (@(posedge clk_c) disable iff (rst_c)
        (en_c && !sel_p) |=> $stable(rdata));
    end
  endgenerate

endmodule

bind cfg_spram spram_chk #(
  .DATA_W  (DATA_W),
  .OUT_REG (OUT_REG),
  .INV_CLK (INV_CLK),
  .INV_CEN (INV_CEN),
  .INV_LRST(INV_LRST)
) u_chk (
  .clk    (clk),
  .glb_rst(glb_rst),
  .loc_rst(loc_rst),
  .clk_en (clk_en),
  .cs_a   (cs_a),
  .cs_b   (cs_b),
  .wr     (wr),
  .rdata  (rdata)
);

// File: tb/cfg_spram_sweep.sv
module cfg_spram_sweep #(
  parameter int unsigned DW    = 8,
  parameter bit          OREG  = 1'b1,
  parameter bit          ICLK  = 1'b0,
  parameter bit          ICEN  = 1'b0,
  parameter bit          ILRST = 1'b0
) (
  input  logic clk,
  output logic done,
  output int   n_chk,
  output int   n_fail
);

  localparam int DEPTH = 16384 / DW;
  localparam int AW    = $clog2(DEPTH);
  localparam int LAT   = OREG ? 2 : 1;
  localparam bit EN_ON = ICEN ? 1'b0 : 1'b1;
  localparam bit LR_OFF = ILRST ? 1'b1 : 1'b0;

  logic          clk_e;
  logic          gr, lr, ce, ca, cb, w;
  logic [AW-1:0] a;
  logic [DW-1:0] d;
  logic [DW-1:0] q;

  assign clk_e = ICLK ? ~clk : clk;

  cfg_spram #(
    .DATA_W(DW), .OUT_REG(OREG), .INV_CLK(ICLK), .INV_CEN(ICEN), .INV_LRST(ILRST)
  ) u_dut (
    .clk(clk), .glb_rst(gr), .loc_rst(lr), .clk_en(ce), .cs_a(ca), .cs_b(cb),
    .wr(w), .addr(a), .wdata(d), .rdata(q)
  );

  function automatic logic [DW-1:0] pat(input int idx, input int seed);
    int v;
    v = idx * 37 + seed * 101 + (idx >> 3) * 5 + seed;
    return DW'(v ^ (v >> 7));
  endfunction

  task automatic drv(input bit xa, input bit xb, input bit xw, input int ad,
                     input logic [DW-1:0] dv, input bit en);
    ca = xa; cb = xb; w = xw; a = AW'(ad); d = dv; ce = en;
  endtask

  task automatic tick();
    @(negedge clk_e);
    #1;
  endtask

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s (DW=%0d OREG=%0d): got %0h expected %0h", req, DW, OREG, got, exp);
    end
  endtask

  task automatic rd(input int ad, output logic [DW-1:0] v);
    drv(1, 1, 0, ad, '0, EN_ON);
    tick();
    drv(0, 0, 0, ad, '0, EN_ON);
    if (OREG) tick();
    v = q;
  endtask

  task automatic rst_abort(input bit use_loc, input int ad, input logic [DW-1:0] keep);
    logic [DW-1:0] v;
    drv(1, 1, 1, ad, ~keep, EN_ON);
    #1;
    if (use_loc) lr = ~LR_OFF; else gr = 1'b1;
    tick();
    if (OREG) chk("R8 rdata cleared during reset", q, '0);
    if (use_loc) lr = LR_OFF; else gr = 1'b0;
    drv(0, 0, 0, ad, '0, EN_ON);
    tick();
    rd(ad, v);
    chk(use_loc ? "R9 local reset aborts pending write" : "R9 global reset aborts pending write",
        v, keep);
  endtask

  initial begin
    logic [DW-1:0] v;
    logic [DW-1:0] hold;
    done = 1'b0; n_chk = 0; n_fail = 0;
    gr = 1'b1; lr = LR_OFF;
    drv(0, 0, 0, 0, '0, EN_ON);
    repeat (3) tick();
    gr = 1'b0;
    tick();
    if (OREG) chk("R8 reset state", q, '0);

    // Full address sweep, one access per cycle
    for (int i = 0; i < DEPTH; i++) begin
      drv(1, 1, 1, i, pat(i, 1), EN_ON);
      tick();
    end
    drv(0, 0, 0, 0, '0, EN_ON);
    tick();
    for (int i = 0; i < DEPTH + LAT - 1; i++) begin
      if (i < DEPTH) drv(1, 1, 0, i, '0, EN_ON);
      else           drv(0, 0, 0, DEPTH - 1, '0, EN_ON);
      tick();
      if (i + 1 - LAT >= 0) chk("R1 R3 full readback", q, pat(i + 1 - LAT, 1));
    end
    tick();

    // R4: a single select is not enough to write
    drv(1, 0, 1, 0, ~pat(0, 1), EN_ON); tick();
    drv(0, 1, 1, 0, ~pat(0, 1), EN_ON); tick();
    drv(0, 0, 0, 0, '0, EN_ON); tick();
    rd(0, v);
    chk("R4 half select blocks write", v, pat(0, 1));

    // R5: registered output holds across write and deselected cycles
    if (OREG) begin
      rd(1, v);
      chk("R5 registered read latency", v, pat(1, 1));
      drv(1, 1, 1, 2, pat(2, 7), EN_ON); tick();
      drv(0, 0, 0, 2, '0, EN_ON); tick();
      chk("R5 rdata held over write cycle", q, pat(1, 1));
      drv(0, 1, 0, 3, '0, EN_ON); tick(); tick();
      chk("R4 rdata held while deselected", q, pat(1, 1));
    end else begin
      // R6: combinational output follows the captured address
      drv(1, 1, 1, 2, pat(2, 7), EN_ON); tick();
      chk("R6 old word before writing edge", q, pat(2, 1));
      drv(0, 0, 0, 2, '0, EN_ON); tick();
      chk("R6 new word after writing edge", q, pat(2, 7));
    end
    rd(2, v);
    chk("R3 directed write", v, pat(2, 7));

    // R7: inactive enable freezes capture, array and output
    rd(4, hold);
    drv(1, 1, 1, 3, pat(3, 5), ~EN_ON); tick(); tick();
    chk("R7 rdata held while disabled", q, hold);
    drv(1, 1, 0, 5, '0, ~EN_ON); tick(); tick();
    chk("R7 rdata held on disabled read", q, hold);
    drv(0, 0, 0, 3, '0, EN_ON); tick();
    rd(3, v);
    chk("R7 no write while disabled", v, pat(3, 1));

    // R2: a change after the capturing edge does not alter the access
    drv(1, 1, 1, 4, pat(4, 3), EN_ON); tick();
    drv(0, 0, 1, 4, pat(4, 8), EN_ON); tick();
    drv(0, 0, 0, 4, '0, EN_ON); tick();
    rd(4, v);
    chk("R2 captured data written", v, pat(4, 3));

    // R10: inputs withdrawn just after the active edge still act
    drv(1, 1, 1, 7, pat(7, 6), EN_ON);
    @(posedge clk_e);
    #1;
    drv(0, 0, 0, 7, '0, EN_ON);
    tick(); tick();
    rd(7, v);
    chk("R10 capture on selected edge", v, pat(7, 6));

    // R8 / R9: reset during a pending write, each source alone
    rst_abort(1'b0, 5, pat(5, 1));
    rst_abort(1'b1, 6, pat(6, 1));
    rd(0, v);
    chk("R8 contents survive reset", v, pat(0, 1));

    done = 1'b1;
  end

endmodule

// File: tb/cfg_spram_tb.sv
module cfg_spram_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       dn [7];
  int         nc [7];
  int         nf [7];

  cfg_spram_sweep #(.DW(1),  .OREG(1), .ICLK(0), .ICEN(0), .ILRST(0)) s_w1  (.clk(clk), .done(dn[0]), .n_chk(nc[0]), .n_fail(nf[0]));
  cfg_spram_sweep #(.DW(2),  .OREG(1), .ICLK(0), .ICEN(0), .ILRST(0)) s_w2  (.clk(clk), .done(dn[1]), .n_chk(nc[1]), .n_fail(nf[1]));
  cfg_spram_sweep #(.DW(4),  .OREG(0), .ICLK(1), .ICEN(1), .ILRST(1)) s_w4  (.clk(clk), .done(dn[2]), .n_chk(nc[2]), .n_fail(nf[2]));
  cfg_spram_sweep #(.DW(8),  .OREG(1), .ICLK(0), .ICEN(0), .ILRST(0)) s_w8  (.clk(clk), .done(dn[3]), .n_chk(nc[3]), .n_fail(nf[3]));
  cfg_spram_sweep #(.DW(16), .OREG(0), .ICLK(0), .ICEN(0), .ILRST(0)) s_w16 (.clk(clk), .done(dn[4]), .n_chk(nc[4]), .n_fail(nf[4]));
  cfg_spram_sweep #(.DW(32), .OREG(1), .ICLK(1), .ICEN(1), .ILRST(1)) s_w32 (.clk(clk), .done(dn[5]), .n_chk(nc[5]), .n_fail(nf[5]));
  cfg_spram_sweep #(.DW(8),  .OREG(0), .ICLK(0), .ICEN(1), .ILRST(0)) s_w8a (.clk(clk), .done(dn[6]), .n_chk(nc[6]), .n_fail(nf[6]));

  // Stand-in for the default instance name of the house style
  logic u_dut_all_done;
  assign u_dut_all_done = dn[0] & dn[1] & dn[2] & dn[3] & dn[4] & dn[5] & dn[6];

  initial begin
    int  tot_c;
    int  tot_f;
    bit  timed_out;
    timed_out = 1'b0;
    fork
      begin
        wait (u_dut_all_done === 1'b1);
      end
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    tot_c = 0;
    tot_f = 0;
    for (int k = 0; k < 7; k++) begin
      tot_c += nc[k];
      tot_f += nf[k];
    end
    if (timed_out) begin
      tot_c++;
      tot_f++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", tot_c, tot_f);
    $finish;
  end

endmodule